// File: doc/BRIEF.md
# Two-Level Thread and Frame Scheduler

This block decides which fine-grained thread runs next on one processor. Threads belong to activation frames. Each frame owns a small last-in, first-out stack of pending thread start addresses. Frames that have pending work wait their turn in a first-in, first-out queue of runnable frames. The processor reports its progress through three commands:
- fork: a new thread address goes onto the running frame's stack.
- stop: the current thread has ended, so the next address is popped.
- swap: the running frame is exhausted, so the scheduler moves to the next runnable frame and issues that frame's enter-thread address.

Values that arrive for a frame come in on a separate inlet port. Each one pushes a thread address onto the stack of its frame. If that frame is idle, the inlet also places the frame in the runnable queue.

When a frame is activated, the scheduler records the frame's enter address. It also seeds the frame's stack with the frame's exit-code address. That address sits at the bottom of the stack, so it runs only after every other pending thread of that frame has run. The result is that control leaves a frame only once its work has run out. A swap issued while the running frame still holds pending threads is ignored. A swap issued while no frame is runnable stays pending until a frame becomes runnable.

Top module: `frame_scheduler`

## Requirements
- R1: After reset, `next_pc_valid`, `run_frame_valid` and `stack_overflow` are all low.
- R2: A fork (`cmd_op` = 0) pushes `cmd_pc` onto the running frame's stack. A stop (`cmd_op` = 1) pops the most recent entry and presents it on `next_pc` with `next_pc_valid` high for one cycle, in the cycle after the command.
- R3: Activating a frame sets its stack to hold only `act_exit_pc`, and records `act_enter_pc` as the frame's enter address. The exit address is returned by the stop that finds no other entry above it.
- R4: An inlet pushes `inlet_pc` onto the stack of frame `inlet_frame`, whether or not that frame is running.
- R5: An inlet to a frame that is neither running nor queued appends that frame to the runnable queue. Frames leave the queue in the order they entered it.
- R6: A frame already in the runnable queue is not appended again by further inlets.
- R7: A swap (`cmd_op` = 2) accepted with a non-empty queue removes the head frame and makes it the running frame (`run_frame`, `run_frame_valid`). In the cycle after the swap, it presents that frame's enter address on `next_pc` with `next_pc_valid` high.
- R8: A swap issued while the running frame's stack is not empty is ignored. The running frame and the outputs are left unchanged.
- R9: A swap accepted while the queue is empty leaves no frame running and keeps `next_pc_valid` low. When a frame is later appended by an inlet, the enter address appears one cycle after the cycle of that inlet.
- R10: A push (fork or inlet) to a stack already holding `STACK_DEPTH` entries is dropped, and `stack_overflow` is high for one cycle, in the cycle after it.
- R11: A stop while the running stack is empty, and any fork or stop while no frame is running, produce no output and change no stack.
- R12: An inlet to the running frame does not place that frame in the runnable queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate frame `act_frame` this cycle |
| act_frame | input | FID_W | Frame being activated |
| act_enter_pc | input | PC_W | Enter-thread address of the activated frame |
| act_exit_pc | input | PC_W | Exit-code address seeded at the stack bottom |
| cmd_valid | input | 1 | A command is present |
| cmd_op | input | 2 | 0 fork, 1 stop, 2 swap |
| cmd_pc | input | PC_W | Thread address for fork |
| inlet_valid | input | 1 | An inlet post is present |
| inlet_frame | input | FID_W | Target frame of the inlet |
| inlet_pc | input | PC_W | Thread address posted by the inlet |
| next_pc_valid | output | 1 | `next_pc` holds an address to run |
| next_pc | output | PC_W | Next thread address |
| run_frame_valid | output | 1 | A frame is currently running |
| run_frame | output | FID_W | Identifier of the running frame |
| stack_overflow | output | 1 | A push was dropped in the previous cycle |

## Verification
The checker watches four behaviours on every cycle:
- every change of running frame comes with an enter address;
- the running frame changes only in response to a swap;
- an address never appears on `next_pc` without a command or an inlet in the cycles that can cause it;
- an overflow is only ever raised by a push.

Stack ordering needs the bench's directed scenarios, because only they can show it. The same holds for the exit address running last, for the queue order across frames, for refused duplicate enqueues, for ignored early swaps, for the waiting swap, and for the fact that the dropped address is really gone.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        OP_FORK = 2'd0,
        OP_STOP = 2'd1,
        OP_SWAP = 2'd2
    } sched_op_e;
endpackage

// File: rtl/pc_stack.sv
module pc_stack #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seed_en,
    input  logic [PC_W-1:0] seed_pc,
    input  logic            pop_en,
    input  logic            push0_en,
    input  logic [PC_W-1:0] push0_pc,
    input  logic            push1_en,
    input  logic [PC_W-1:0] push1_pc,
    output logic [PC_W-1:0] top_pc,
    output logic            empty,
    output logic            overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [CNT_W-1:0]           cnt;
    } stk_t;

    stk_t             q, d;
    logic [CNT_W-1:0] lvl;
    logic [CNT_W-1:0] top_idx;

    // Pop happens first, then the command push, then the inlet push.
    always_comb begin
        d        = q;
        overflow = 1'b0;
        lvl      = q.cnt;
        if (seed_en) begin
            d.mem[0] = seed_pc;
            d.cnt    = CNT_W'(1);
        end else begin
            if (pop_en && q.cnt != '0) lvl = q.cnt - CNT_W'(1);
            if (push0_en) begin
                if (lvl < CNT_W'(DEPTH)) begin
                    d.mem[lvl[IDX_W-1:0]] = push0_pc;
                    lvl = lvl + CNT_W'(1);
                end else begin
                    overflow = 1'b1;
                end
            end
            if (push1_en) begin
                if (lvl < CNT_W'(DEPTH)) begin
                    d.mem[lvl[IDX_W-1:0]] = push1_pc;
                    lvl = lvl + CNT_W'(1);
                end else begin
                    overflow = 1'b1;
                end
            end
            d.cnt = lvl;
        end
    end

    always_comb begin
        top_idx = q.cnt - CNT_W'(1);
        top_pc  = q.mem[top_idx[IDX_W-1:0]];
        empty   = (q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/run_queue.sv
module run_queue #(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            empty
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ENTRIES-1:0][ID_W-1:0] slot;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } rq_t;

    rq_t  q, d;
    logic do_pop, do_push;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (q.cnt < CNT_W'(ENTRIES) || do_pop);
        if (do_pop)  d.rd = wrap_inc(q.rd);
        if (do_push) begin
            d.slot[q.wr] = push_id;
            d.wr         = wrap_inc(q.wr);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CNT_W'(1);
            2'b01:   d.cnt = q.cnt - CNT_W'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    assign head_id = q.slot[q.rd];
    assign empty   = (q.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/frame_scheduler.sv
module frame_scheduler
    import sched_pkg::*;
#(
    parameter int NUM_FRAMES  = 4,
    parameter int STACK_DEPTH = 4,
    parameter int PC_W        = 16,
    localparam int FID_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [FID_W-1:0] act_frame,
    input  logic [PC_W-1:0]  act_enter_pc,
    input  logic [PC_W-1:0]  act_exit_pc,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [PC_W-1:0]  cmd_pc,
    input  logic             inlet_valid,
    input  logic [FID_W-1:0] inlet_frame,
    input  logic [PC_W-1:0]  inlet_pc,
    output logic             next_pc_valid,
    output logic [PC_W-1:0]  next_pc,
    output logic             run_frame_valid,
    output logic [FID_W-1:0] run_frame,
    output logic             stack_overflow
);
    typedef struct packed {
        logic [FID_W-1:0]                cur;
        logic                            cur_valid;
        logic                            pending;
        logic [NUM_FRAMES-1:0]           queued;
        logic [NUM_FRAMES-1:0][PC_W-1:0] enter_pc;
        logic                            out_valid;
        logic [PC_W-1:0]                 out_pc;
        logic                            ovf;
    } sched_t;

    sched_t q, d;

    logic [NUM_FRAMES-1:0]           stk_seed, stk_pop, stk_push0, stk_push1;
    logic [NUM_FRAMES-1:0]           stk_empty, stk_ovf;
    logic [NUM_FRAMES-1:0][PC_W-1:0] stk_top;
    logic                            rq_push, rq_pop, rq_empty;
    logic [FID_W-1:0]                rq_push_id, rq_head;
    logic                            swap_req;
    sched_op_e                       op;

    generate
        for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_stack
            pc_stack #(.DEPTH(STACK_DEPTH), .PC_W(PC_W)) u_stack (
                .clk      (clk),
                .rst_n    (rst_n),
                .seed_en  (stk_seed[f]),
                .seed_pc  (act_exit_pc),
                .pop_en   (stk_pop[f]),
                .push0_en (stk_push0[f]),
                .push0_pc (cmd_pc),
                .push1_en (stk_push1[f]),
                .push1_pc (inlet_pc),
                .top_pc   (stk_top[f]),
                .empty    (stk_empty[f]),
                .overflow (stk_ovf[f])
            );
        end
    endgenerate

    run_queue #(.ENTRIES(NUM_FRAMES), .ID_W(FID_W)) u_rq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rq_push),
        .push_id (rq_push_id),
        .pop     (rq_pop),
        .head_id (rq_head),
        .empty   (rq_empty)
    );

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.ovf       = |stk_ovf;
        stk_seed    = '0;
        stk_pop     = '0;
        stk_push0   = '0;
        stk_push1   = '0;
        rq_push     = 1'b0;
        rq_pop      = 1'b0;
        rq_push_id  = inlet_frame;
        swap_req    = q.pending;
        op          = sched_op_e'(cmd_op);

        // activation: seed exit address, remember enter address
        if (act_valid) begin
            stk_seed[act_frame]   = 1'b1;
            d.enter_pc[act_frame] = act_enter_pc;
        end

        // thread-level commands act on the running frame only
        if (cmd_valid && q.cur_valid) begin
            case (op)
                OP_FORK: stk_push0[q.cur] = 1'b1;
                OP_STOP: begin
                    if (!stk_empty[q.cur]) begin
                        stk_pop[q.cur] = 1'b1;
                        d.out_valid    = 1'b1;
                        d.out_pc       = stk_top[q.cur];
                    end
                end
                default: ;
            endcase
        end

        // swap is accepted only once the running frame has no work left
        if (cmd_valid && op == OP_SWAP && (!q.cur_valid || stk_empty[q.cur]))
            swap_req = 1'b1;

        if (swap_req) begin
            if (!rq_empty) begin
                rq_pop            = 1'b1;
                d.cur             = rq_head;
                d.cur_valid       = 1'b1;
                d.queued[rq_head] = 1'b0;
                d.pending         = 1'b0;
                d.out_valid       = 1'b1;
                d.out_pc          = q.enter_pc[rq_head];
            end else begin
                d.pending   = 1'b1;
                d.cur_valid = 1'b0;
            end
        end

        // inlets push anywhere; idle frames become runnable
        if (inlet_valid) begin
            stk_push1[inlet_frame] = 1'b1;
            if (!(d.cur_valid && d.cur == inlet_frame) && !d.queued[inlet_frame]) begin
                rq_push                = 1'b1;
                d.queued[inlet_frame]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign next_pc_valid   = q.out_valid;
    assign next_pc         = q.out_pc;
    assign run_frame_valid = q.cur_valid;
    assign run_frame       = q.cur;
    assign stack_overflow  = q.ovf;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
    parameter int FID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             inlet_valid,
    input logic             next_pc_valid,
    input logic             run_frame_valid,
    input logic [FID_W-1:0] run_frame,
    input logic             stack_overflow
);
    assert_enter_on_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_frame_valid && (!$past(run_frame_valid) || run_frame != $past(run_frame)))
        |-> next_pc_valid);

    assert_switch_needs_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_frame_valid && $past(run_frame_valid) && run_frame != $past(run_frame))
        |-> ($past(cmd_valid) && $past(cmd_op) == 2'd2));

    assert_no_spurious_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc_valid |-> ($past(cmd_valid) || $past(inlet_valid, 2)));

    assert_overflow_from_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |-> ($past(cmd_valid) || $past(inlet_valid)));
endmodule

bind frame_scheduler sched_checker #(.FID_W(FID_W)) u_sched_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_op          (cmd_op),
    .inlet_valid     (inlet_valid),
    .next_pc_valid   (next_pc_valid),
    .run_frame_valid (run_frame_valid),
    .run_frame       (run_frame),
    .stack_overflow  (stack_overflow)
);

// File: tb/frame_scheduler_tb.sv
module frame_scheduler_tb;
    localparam int FID_W = 2;
    localparam int PC_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             act_valid = 1'b0;
    logic [FID_W-1:0] act_frame = '0;
    logic [PC_W-1:0]  act_enter_pc = '0, act_exit_pc = '0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = '0;
    logic [PC_W-1:0]  cmd_pc = '0;
    logic             inlet_valid = 1'b0;
    logic [FID_W-1:0] inlet_frame = '0;
    logic [PC_W-1:0]  inlet_pc = '0;
    logic             next_pc_valid, run_frame_valid, stack_overflow;
    logic [PC_W-1:0]  next_pc;
    logic [FID_W-1:0] run_frame;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    frame_scheduler u_dut (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_frame(act_frame),
        .act_enter_pc(act_enter_pc), .act_exit_pc(act_exit_pc),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pc(cmd_pc),
        .inlet_valid(inlet_valid), .inlet_frame(inlet_frame), .inlet_pc(inlet_pc),
        .next_pc_valid(next_pc_valid), .next_pc(next_pc),
        .run_frame_valid(run_frame_valid), .run_frame(run_frame),
        .stack_overflow(stack_overflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // each op occupies one clock; outputs sampled 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
        act_valid = 1'b0; cmd_valid = 1'b0; inlet_valid = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [PC_W-1:0] pc);
        cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc;
        step();
    endtask

    task automatic do_inlet(input int f, input logic [PC_W-1:0] pc);
        inlet_valid = 1'b1; inlet_frame = FID_W'(f); inlet_pc = pc;
        step();
    endtask

    task automatic do_act(input int f, input logic [PC_W-1:0] en, input logic [PC_W-1:0] ex);
        act_valid = 1'b1; act_frame = FID_W'(f); act_enter_pc = en; act_exit_pc = ex;
        step();
    endtask

    task automatic expect_pc(input string tag, input logic [PC_W-1:0] pc);
        chk(next_pc_valid === 1'b1 && next_pc === pc, tag,
            next_pc_valid ? int'(next_pc) : -1, int'(pc));
    endtask

    task automatic expect_none(input string tag);
        chk(next_pc_valid === 1'b0, tag, int'(next_pc_valid), 0);
    endtask

    task automatic expect_frame(input string tag, input int f);
        chk(run_frame_valid === 1'b1 && run_frame === FID_W'(f), tag,
            run_frame_valid ? int'(run_frame) : -1, f);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        chk(next_pc_valid === 1'b0, "R1 next_pc_valid", int'(next_pc_valid), 0);
        chk(run_frame_valid === 1'b0, "R1 run_frame_valid", int'(run_frame_valid), 0);
        chk(stack_overflow === 1'b0, "R1 stack_overflow", int'(stack_overflow), 0);
    endtask

    task automatic t_first_frame();
        do_act(0, 16'h0100, 16'h01FF);      expect_none("R3 activation silent");
        do_inlet(0, 16'h0110);              expect_none("R5 inlet enqueues silently");
        do_cmd(2'd2, '0);                   expect_pc("R7 swap enter pc", 16'h0100);
        expect_frame("R7 running frame", 0);
        do_cmd(2'd1, '0);                   expect_pc("R4 inlet address", 16'h0110);
        do_cmd(2'd0, 16'h0120);             expect_none("R2 fork silent");
        do_cmd(2'd0, 16'h0130);
        do_cmd(2'd1, '0);                   expect_pc("R2 lifo first", 16'h0130);
        do_cmd(2'd1, '0);                   expect_pc("R2 lifo second", 16'h0120);
        do_cmd(2'd1, '0);                   expect_pc("R3 exit runs last", 16'h01FF);
        do_cmd(2'd1, '0);                   expect_none("R11 stop on empty");
    endtask

    task automatic t_pending_swap();
        do_cmd(2'd2, '0);                   expect_none("R9 swap on empty queue");
        chk(run_frame_valid === 1'b0, "R9 no running frame", int'(run_frame_valid), 0);
        step();                             expect_none("R9 still waiting");
        do_cmd(2'd0, 16'h0999);             expect_none("R11 fork with no frame");
        do_act(1, 16'h0200, 16'h02FF);      expect_none("R9 activation does not wake");
        do_inlet(1, 16'h0210);              expect_none("R9 inlet cycle");
        step();                             expect_pc("R9 wakes one cycle later", 16'h0200);
        expect_frame("R9 frame", 1);
    endtask

    task automatic t_queue_order();
        do_act(2, 16'h0400, 16'h04FF);
        do_act(3, 16'h0300, 16'h03FF);
        do_inlet(3, 16'h0310);
        do_inlet(2, 16'h0220);
        do_inlet(3, 16'h0320);
        do_inlet(1, 16'h0230);
        do_cmd(2'd2, '0);                   expect_none("R8 early swap ignored");
        expect_frame("R8 frame kept", 1);
        do_cmd(2'd1, '0);                   expect_pc("R12 inlet to running frame", 16'h0230);
        do_cmd(2'd1, '0);                   expect_pc("R11 stray fork absent", 16'h0210);
        do_cmd(2'd1, '0);                   expect_pc("R3 frame1 exit", 16'h02FF);
        do_cmd(2'd2, '0);                   expect_pc("R5 first queued frame", 16'h0300);
        expect_frame("R5 frame3 runs", 3);
        do_cmd(2'd1, '0);                   expect_pc("R4 frame3 top", 16'h0320);
        do_cmd(2'd1, '0);                   expect_pc("R4 frame3 next", 16'h0310);
        do_cmd(2'd1, '0);                   expect_pc("R3 frame3 exit", 16'h03FF);
        do_cmd(2'd2, '0);                   expect_pc("R5 second queued frame", 16'h0400);
        expect_frame("R5 frame2 runs", 2);
        do_cmd(2'd1, '0);                   expect_pc("R4 frame2 top", 16'h0220);
        do_cmd(2'd1, '0);                   expect_pc("R3 frame2 exit", 16'h04FF);
        do_cmd(2'd2, '0);                   expect_none("R6 R12 no duplicate entries");
        step();                             expect_none("R6 queue stays empty");
    endtask

    task automatic t_overflow();
        do_act(0, 16'h0500, 16'h05FF);
        do_inlet(0, 16'h0510);              expect_none("R9 inlet cycle");
        step();                             expect_pc("R9 pending swap served", 16'h0500);
        do_cmd(2'd0, 16'h0520);
        chk(stack_overflow === 1'b0, "R10 no overflow at 3", int'(stack_overflow), 0);
        do_cmd(2'd0, 16'h0530);
        chk(stack_overflow === 1'b0, "R10 no overflow at 4", int'(stack_overflow), 0);
        do_cmd(2'd0, 16'h0540);
        chk(stack_overflow === 1'b1, "R10 overflow flagged", int'(stack_overflow), 1);
        step();
        chk(stack_overflow === 1'b0, "R10 overflow one cycle", int'(stack_overflow), 0);
        do_cmd(2'd1, '0);                   expect_pc("R10 dropped push absent", 16'h0530);
        do_cmd(2'd1, '0);                   expect_pc("R2 after overflow", 16'h0520);
        do_cmd(2'd1, '0);                   expect_pc("R4 inlet below forks", 16'h0510);
        do_cmd(2'd1, '0);                   expect_pc("R3 exit after overflow", 16'h05FF);
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_pending_swap();
        t_queue_order();
        t_overflow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule